// File: doc/BRIEF.md
# Iterative Multiply Coprocessor

This unit sits beside a small processor core and executes the four 32-bit integer multiply instructions for it: the low-word product and three high-word products that differ in operand signedness. The host presents a request strobe together with the raw instruction word and the two source operand values. The unit decodes the word. If the word is one of its multiplies, it claims the request with a busy/claim signal, computes the product with a one-bit-per-cycle shift-add engine and returns a result word. The result comes with a one-cycle ready pulse and a matching write strobe.

Words that are not multiplies get no response at all. The host sees no claim and can treat the instruction as illegal after its own timeout. The low-word product needs only XLEN iterations. The high-word variants need 2*XLEN iterations over sign- or zero-extended operands, so their latency is about twice as long. After a completed operation the unit ignores the request strobe until the host has dropped it. This prevents a held request from being executed twice.

Top module: `mul_cop`

## Requirements
- R1: A request is claimed only when the instruction has opcode bits [6:0] = 0110011, funct7 bits [31:25] = 0000001 and funct3 bits [14:12] in 000..011.
- R2: Any other instruction word, presented with the request strobe held high, leaves claim, ready and write strobe low for as long as it is held.
- R3: The claim output is high in the first cycle after the cycle in which a multiply request is presented. It stays high until the ready cycle and is low in the ready cycle.
- R4: funct3 000 returns bits [31:0] of the product of the two operands.
- R5: funct3 001 returns bits [63:32] of the product with both operands signed.
- R6: funct3 010 returns bits [63:32] of the product with the first operand signed and the second unsigned.
- R7: funct3 011 returns bits [63:32] of the product with both operands unsigned.
- R8: For funct3 000, ready is high exactly XLEN+1 cycles after the cycle in which the request is first presented.
- R9: For funct3 001..011, ready is high exactly 2*XLEN+1 cycles after the cycle in which the request is first presented.
- R10: Ready is a single-cycle pulse. The write strobe equals ready. The result output is zero whenever ready is low.
- R11: After a completed operation, a request strobe that is still held high starts nothing: no claim and no ready appear until the strobe has been low for at least one cycle.
- R12: While reset is asserted and after its release, with no request, claim, ready, write strobe and result are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request strobe |
| req_insn_i | input | XLEN | Instruction word |
| req_src_a_i | input | XLEN | First source operand |
| req_src_b_i | input | XLEN | Second source operand |
| rsp_wr_o | output | 1 | Result write strobe |
| rsp_data_o | output | XLEN | Result word |
| rsp_wait_o | output | 1 | Claim: instruction accepted, computation in progress |
| rsp_ready_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets operands at the signed extremes. These are 0x80000000 squared, all-ones times all-ones, and all-ones against a large unsigned value under the mixed-sign variant. A unit that extends an operand with the wrong sign, or runs too few iterations for the high word, returns a wrong upper half only in these cases. Exact ready latency is measured for both iteration counts, so an off-by-one iteration counter is caught. Near-miss encodings are presented and must stay unclaimed: a divide funct3, a zero funct7 and a different opcode. A request is held high across completion, which exposes a unit that restarts and reports the same operation twice.

// File: rtl/mul_cop_pkg.sv
package mul_cop_pkg;
  typedef enum logic [1:0] {
    OP_LO   = 2'b00,
    OP_HISS = 2'b01,
    OP_HISU = 2'b10,
    OP_HIUU = 2'b11
  } mul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_DONE,
    ST_HOLD
  } mul_state_e;

  localparam logic [6:0] OPC_ARITH = 7'b0110011;
  localparam logic [6:0] F7_MULDIV = 7'b0000001;
endpackage

// File: rtl/mul_cop_decode.sv
module mul_cop_decode
  import mul_cop_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] insn_i,
  output logic            hit_o,
  output mul_op_e         op_o
);
  always_comb begin
    hit_o = (insn_i[6:0] == OPC_ARITH) && (insn_i[31:25] == F7_MULDIV) && !insn_i[14];
    op_o  = mul_op_e'(insn_i[13:12]);
  end
endmodule

// File: rtl/mul_cop_ctrl.sv
module mul_cop_ctrl
  import mul_cop_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic hit_i,
  input  logic high_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(2 * XLEN + 1);
  localparam logic [CNT_W-1:0] LO_CNT = CNT_W'(XLEN);
  localparam logic [CNT_W-1:0] HI_CNT = CNT_W'(2 * XLEN);

  mul_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (valid_i && hit_i) begin
        load_o  = 1'b1;
        state_d = ST_BUSY;
      end
      ST_BUSY: begin
        step_o = 1'b1;
        if (cnt_q == CNT_W'(1)) state_d = ST_DONE;
      end
      ST_DONE: state_d = valid_i ? ST_HOLD : ST_IDLE;
      ST_HOLD: if (!valid_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)      cnt_q <= high_i ? HI_CNT : LO_CNT;
      else if (step_o) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (state_q == ST_BUSY);
  assign done_o = (state_q == ST_DONE);

  // R3
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o || done_o);
  // R1
  claim_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(valid_i) && $past(hit_i));
  // R11
  no_restart_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && valid_i |=> !busy_o);
endmodule

// File: rtl/mul_cop_datapath.sv
module mul_cop_datapath
  import mul_cop_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  mul_op_e         op_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [XLEN-1:0] result_o
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0] mcand_q, mplier_q, acc_q;
  logic          hi_q;
  logic          sgn_a, sgn_b;

  assign sgn_a = (op_i == OP_HISS) || (op_i == OP_HISU);
  assign sgn_b = (op_i == OP_HISS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      hi_q     <= 1'b0;
    end else if (load_i) begin
      mcand_q  <= {{XLEN{sgn_a & src_a_i[XLEN-1]}}, src_a_i};
      mplier_q <= {{XLEN{sgn_b & src_b_i[XLEN-1]}}, src_b_i};
      acc_q    <= '0;
      hi_q     <= (op_i != OP_LO);
    end else if (step_i) begin
      if (mplier_q[0]) acc_q <= acc_q + mcand_q;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  assign result_o = hi_q ? acc_q[PW-1:XLEN] : acc_q[XLEN-1:0];
endmodule

// File: rtl/mul_cop.sv
module mul_cop
  import mul_cop_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [XLEN-1:0] req_insn_i,
  input  logic [XLEN-1:0] req_src_a_i,
  input  logic [XLEN-1:0] req_src_b_i,
  output logic            rsp_wr_o,
  output logic [XLEN-1:0] rsp_data_o,
  output logic            rsp_wait_o,
  output logic            rsp_ready_o
);
  logic            hit, load, step, busy, done;
  mul_op_e         op;
  logic [XLEN-1:0] result;

  mul_cop_decode #(.XLEN(XLEN)) u_dec (
    .insn_i(req_insn_i), .hit_o(hit), .op_o(op)
  );

  mul_cop_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk_i, .rst_ni, .valid_i(req_valid_i), .hit_i(hit),
    .high_i(op != OP_LO), .load_o(load), .step_o(step),
    .busy_o(busy), .done_o(done)
  );

  mul_cop_datapath #(.XLEN(XLEN)) u_dp (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .op_i(op),
    .src_a_i(req_src_a_i), .src_b_i(req_src_b_i), .result_o(result)
  );

  assign rsp_wait_o  = busy;
  assign rsp_ready_o = done;
  assign rsp_wr_o    = done;
  assign rsp_data_o  = done ? result : '0;

  // R10
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |=> !rsp_ready_o);
  // R3
  ready_after_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |-> $past(rsp_wait_o) && !rsp_wait_o);
endmodule

// File: tb/mul_cop_tb_top.sv
`timescale 1ns/1ps
module mul_cop_tb_top;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0;
  logic [XLEN-1:0] insn = '0, src_a = '0, src_b = '0;
  logic            wr, ready, wt;
  logic [XLEN-1:0] data;
  int              checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  mul_cop #(.XLEN(XLEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_insn_i(insn),
    .req_src_a_i(src_a), .req_src_b_i(src_b), .rsp_wr_o(wr),
    .rsp_data_o(data), .rsp_wait_o(wt), .rsp_ready_o(ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_insn(input logic [6:0] f7, input logic [2:0] f3,
                                          input logic [6:0] opc);
    return {f7, 5'd3, 5'd2, f3, 5'd1, opc};
  endfunction

  function automatic logic [31:0] ref_mul(input logic [1:0] f3, input logic [31:0] a,
                                          input logic [31:0] b);
    logic [63:0] ea, eb, p;
    ea = {{32{(f3 == 2'b01 || f3 == 2'b10) && a[31]}}, a};
    eb = {{32{(f3 == 2'b01) && b[31]}}, b};
    p  = ea * eb;
    return (f3 == 2'b00) ? p[31:0] : p[63:32];
  endfunction

  // Runs one multiply; leaves valid high afterwards if keep is set.
  task automatic do_mul(input logic [1:0] f3, input logic [31:0] a,
                        input logic [31:0] b, input bit keep);
    string rq;
    int    cyc = 0;
    int    exp_lat;
    bit    bad = 0;
    case (f3)
      2'b00:   rq = "R4";
      2'b01:   rq = "R5";
      2'b10:   rq = "R6";
      default: rq = "R7";
    endcase
    exp_lat = (f3 == 2'b00) ? XLEN + 1 : 2 * XLEN + 1;
    insn  = mk_insn(7'b0000001, {1'b0, f3}, 7'b0110011);
    src_a = a;
    src_b = b;
    valid = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(wt == 1'b1, "R3", "claim in first cycle", wt, 1);
      if (!ready && (!wt || data != '0 || wr)) bad = 1;
    end while (!ready && cyc < 300);
    check(!bad, "R10", "wait held, data zero, wr low before ready", bad, 0);
    check(data == ref_mul(f3, a, b), rq, "result", data, ref_mul(f3, a, b));
    check(wr == 1'b1 && wt == 1'b0, "R10", "wr with ready, wait low (R3)", {wr, wt}, 2'b10);
    check(cyc == exp_lat, (f3 == 2'b00) ? "R8" : "R9", "latency", cyc, exp_lat);
    if (!keep) valid = 1'b0;
    @(negedge clk);
    check(ready == 1'b0 && data == '0, "R10", "ready single pulse", {ready, data}, 0);
  endtask

  task automatic test_reset();
    check(!wt && !ready && !wr && data == '0, "R12", "outputs in reset",
          {wt, ready, wr, data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!wt && !ready && !wr && data == '0, "R12", "outputs after reset",
          {wt, ready, wr, data}, 0);
  endtask

  task automatic test_ignore(input logic [31:0] w, input string what);
    bit bad = 0;
    insn  = w;
    src_a = 32'h1234_5678;
    src_b = 32'h9;
    valid = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (wt || ready || wr) bad = 1;
    end
    valid = 1'b0;
    check(!bad, "R2", what, bad, 0);
    @(negedge clk);
  endtask

  task automatic test_decode_hits();
    for (int f = 0; f < 4; f++) begin
      insn  = mk_insn(7'b0000001, f[2:0], 7'b0110011);
      valid = 1'b1;
      @(negedge clk);
      check(wt == 1'b1, "R1", "multiply funct3 claimed", wt, 1);
      valid = 1'b0;
      while (!ready) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic test_held_valid();
    bit bad = 0;
    do_mul(2'b00, 32'd7, 32'd6, 1'b1);
    repeat (12) begin
      @(negedge clk);
      if (wt || ready) bad = 1;
    end
    check(!bad, "R11", "held valid does not restart", bad, 0);
    valid = 1'b0;
    @(negedge clk);
    do_mul(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic test_corners();
    logic [31:0] av[6] = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h7FFF_FFFF, 32'h1, 32'hFFFF_FFFF};
    logic [31:0] bv[6] = '{32'h8000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0001};
    for (int i = 0; i < 6; i++)
      for (int f = 0; f < 4; f++) do_mul(f[1:0], av[i], bv[i], 1'b0);
  endtask

  task automatic test_random();
    for (int i = 0; i < 10; i++)
      for (int f = 0; f < 4; f++) do_mul(f[1:0], $urandom, $urandom, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_ignore(mk_insn(7'b0000001, 3'b100, 7'b0110011), "divide funct3 ignored (R1)");
    test_ignore(mk_insn(7'b0000000, 3'b000, 7'b0110011), "zero funct7 ignored (R1)");
    test_ignore(mk_insn(7'b0000001, 3'b000, 7'b0010011), "other opcode ignored (R1)");
    test_decode_hits();
    test_corners();
    test_random();
    test_held_valid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule